// File: doc/BRIEF.md
# Indirect Reconfiguration Register Controller

This block is a memory-mapped slave that gives software indirect access to the registers of a set of transceiver channels. Software picks a logical channel, which the block turns into a physical channel address through a fixed mapping. It loads a register offset and, for writes, a data word. It then sets a trigger bit in the control word. The block carries out the access on a simple request/acknowledge register port towards the channels. While the access runs it reports busy. When the access ends, read data is placed in the data register. If the channel or offset is not usable, the block flags an error instead of issuing the access.

The block writes downstream only in direct-write mode. In that mode every write is a read-modify-write. Bit fields that hold startup-calibrated settings keep their current value, and the protected fields depend on the logical channel. In any other mode a trigger completes at once and makes no downstream access. Trigger bits clear themselves.

Top module: `reconfig_ctrl`

## Requirements
- R1: After reset the logical channel, mode, offset and data registers are zero. Error and busy read as 0, and `dn_req` is low.
- R2: Address 0x38 holds a 10-bit read/write logical channel. Address 0x39 is read-only and returns the physical address: 4*channel+1 for a channel below 8, and 0 for any other channel. Writes to 0x39 are ignored.
- R3: Address 0x3A reads error in bit 9, busy in bit 8 and mode in bits 3:2. Bit 1 (read trigger), bit 0 (write trigger) and every other bit read as 0. Mode is stored on every write to 0x3A.
- R4: Address 0x3B holds an 8-bit offset and address 0x3C holds a 16-bit data word, both read/write. Unmapped addresses read as 0.
- R5: A read trigger with mode 2'b01 and valid settings makes exactly one downstream read of the physical channel at the offset. The returned word is stored in the data register. Busy rises on the edge that accepts the trigger and falls on the edge after the acknowledge.
- R6: A write trigger with mode 2'b01 reads the target register and then writes it back. The written value takes the data register's bits outside the protected mask and keeps the current bits inside it. The mask is 0x0F0F for an even logical channel and 0xF0F0 for an odd one. The data register is unchanged.
- R7: A trigger makes no downstream access, leaves busy low and sets error when any of these holds: the logical channel is 8 or more, the physical address is 28 or more (channel 7), or the offset is 64 or more.
- R8: A trigger accepted with valid settings clears a pending error.
- R9: A valid trigger whose write to 0x3A carries mode 2'b00, 2'b10 or 2'b11 completes at once. It makes no downstream access, busy stays low and error is cleared.
- R10: While busy, triggers and writes to 0x38, 0x3B and 0x3C are ignored.
- R11: When both trigger bits are written as 1, the write operation is performed.
- R12: `dn_req` stays high until `dn_ack` is seen, and busy cannot fall without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 7 | Register address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 16 | Register write data |
| csr_rdata | output | 16 | Register read data, combinational from `csr_addr` |
| dn_req | output | 1 | Downstream access request, held until acknowledged |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_chan | output | 10 | Downstream physical channel address |
| dn_offset | output | 8 | Downstream register offset |
| dn_wdata | output | 16 | Downstream write data |
| dn_rdata | input | 16 | Downstream read data, valid with `dn_ack` |
| dn_ack | input | 1 | Downstream acknowledge, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a trigger or setup write that arrives while an access is in flight. With a quick acknowledge the busy window is over before the next bus write can land. The bench model of the downstream port therefore has a programmable acknowledge latency. The busy test stretches that latency to several cycles and issues a second trigger and an offset write inside the window. It then counts downstream accesses and reads the offset back. The read-modify-write case uses a field-patterned stored word and data word on both an even and an odd channel, so that a wrong or swapped mask changes the value the model stores.

// File: rtl/reconfig_ctrl.sv
module reconfig_ctrl #(
  parameter int NUM_LCH    = 8,
  parameter int PHYS_LIMIT = 28,
  parameter int NUM_OFFS   = 64,
  parameter int DW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    csr_addr,
  input  logic          csr_wr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [9:0]    dn_chan,
  output logic [7:0]    dn_offset,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ack
);
  localparam logic [6:0] A_LCH  = 7'h38;
  localparam logic [6:0] A_PHY  = 7'h39;
  localparam logic [6:0] A_CTL  = 7'h3A;
  localparam logic [6:0] A_OFF  = 7'h3B;
  localparam logic [6:0] A_DAT  = 7'h3C;
  localparam logic [9:0] LCH_N  = 10'(NUM_LCH);
  localparam logic [9:0] PHY_N  = 10'(PHYS_LIMIT);
  localparam logic [8:0] OFF_N  = 9'(NUM_OFFS);
  localparam logic [1:0] M_DIRECT = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           state;
  logic [9:0]    lch_q;
  logic [1:0]    mode_q;
  logic [7:0]    off_q;
  logic [DW-1:0] data_q, cur_q, mask;
  logic          err_q, op_wr_q;

  wire        busy   = (state != S_IDLE);
  wire        lch_ok = (lch_q < LCH_N);
  wire [9:0]  phys   = lch_ok ? {lch_q[7:0], 2'b01} : 10'd0;
  wire        bad    = !lch_ok || (phys >= PHY_N) || ({1'b0, off_q} >= OFF_N);
  wire        wr_ctl = csr_wr && (csr_addr == A_CTL);
  wire        trig   = wr_ctl && !busy && (csr_wdata[0] || csr_wdata[1]);
  wire        setup  = csr_wr && !busy;

  always_comb
    for (int i = 0; i < DW; i++)
      mask[i] = (((i / 4) % 2) != 0) ~^ lch_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      lch_q   <= '0;
      mode_q  <= '0;
      off_q   <= '0;
      data_q  <= '0;
      cur_q   <= '0;
      err_q   <= 1'b0;
      op_wr_q <= 1'b0;
    end else begin
      if (setup && csr_addr == A_LCH) lch_q  <= csr_wdata[9:0];
      if (setup && csr_addr == A_OFF) off_q  <= csr_wdata[7:0];
      if (setup && csr_addr == A_DAT) data_q <= csr_wdata;
      if (wr_ctl) mode_q <= csr_wdata[3:2];
      if (trig) begin
        err_q <= bad;
        if (!bad && csr_wdata[3:2] == M_DIRECT) begin
          state   <= S_RD;
          op_wr_q <= csr_wdata[0];
        end
      end
      case (state)
        S_RD: if (dn_ack) begin
          if (op_wr_q) begin
            cur_q <= dn_rdata;
            state <= S_WR;
          end else begin
            data_q <= dn_rdata;
            state  <= S_IDLE;
          end
        end
        S_WR: if (dn_ack) state <= S_IDLE;
        default: ;
      endcase
    end
  end

  assign dn_req    = busy;
  assign dn_we     = (state == S_WR);
  assign dn_chan   = phys;
  assign dn_offset = off_q;
  assign dn_wdata  = (cur_q & mask) | (data_q & ~mask);

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_LCH: csr_rdata[9:0] = lch_q;
      A_PHY: csr_rdata[9:0] = phys;
      A_CTL: begin
        csr_rdata[9]   = err_q;
        csr_rdata[8]   = busy;
        csr_rdata[3:2] = mode_q;
      end
      A_OFF: csr_rdata[7:0] = off_q;
      A_DAT: csr_rdata = data_q;
      default: ;
    endcase
  end
endmodule

module reconfig_ctrl_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          dn_req,
  input logic          dn_we,
  input logic          dn_ack,
  input logic [DW-1:0] dn_rdata,
  input logic [DW-1:0] dn_wdata,
  input logic [9:0]    lch,
  input logic [6:0]    csr_addr,
  input logic [DW-1:0] csr_rdata
);
  logic [DW-1:0] seen_q;
  wire  [DW-1:0] pmask = lch[0] ? {(DW/8){8'hF0}} : {(DW/8){8'h0F}};

  always_ff @(posedge clk)
    if (!rst_n) seen_q <= '0;
    else if (dn_req && !dn_we && dn_ack) seen_q <= dn_rdata;

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req);
  assert_busy_needs_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dn_ack |=> busy);
  assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dn_ack));
  assert_protected_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_we |-> ((dn_wdata ^ seen_q) & pmask) == '0);
  assert_err_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !dn_req);
  assert_start_clears_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);
  assert_trig_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr == 7'h3A |-> csr_rdata[1:0] == 2'b00);
endmodule

bind reconfig_ctrl reconfig_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err_q), .dn_req(dn_req),
  .dn_we(dn_we), .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_wdata(dn_wdata),
  .lch(lch_q), .csr_addr(csr_addr), .csr_rdata(csr_rdata)
);

// File: tb/tb_reconfig_ctrl.sv
module tb_reconfig_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  csr_addr = 0;
  logic        csr_wr = 0;
  logic [15:0] csr_wdata = 0, csr_rdata, dn_wdata, dn_rdata;
  logic        dn_req, dn_we, dn_ack;
  logic [9:0]  dn_chan;
  logic [7:0]  dn_offset;

  int total = 0, bad = 0, acc_cnt = 0, lat = 0, cnt = 0;
  logic [15:0] mem [2048];

  always #10 clk = ~clk;

  reconfig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dn_req(dn_req),
    .dn_we(dn_we), .dn_chan(dn_chan), .dn_offset(dn_offset),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack)
  );

  initial begin dn_ack = 0; dn_rdata = 0; end
  always @(posedge clk) begin
    if (dn_req && !dn_ack) begin
      if (cnt >= lat) begin
        dn_ack  <= 1;
        cnt     <= 0;
        acc_cnt <= acc_cnt + 1;
        if (dn_we) mem[{dn_chan[4:0], dn_offset[5:0]}] <= dn_wdata;
        else dn_rdata <= mem[{dn_chan[4:0], dn_offset[5:0]}];
      end else cnt <= cnt + 1;
    end else dn_ack <= 0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_wr = 1;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] v);
    @(negedge clk); csr_addr = a; #1 v = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(7'h3A, v);
      if (!v[8]) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(7'h38, v); chk("R1 lch", v, 0);
    rd(7'h3A, v); chk("R1 ctrl", v, 0);
    rd(7'h3B, v); chk("R1 offset", v, 0);
    rd(7'h3C, v); chk("R1 data", v, 0);
    chk("R1 dn_req", dn_req, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(7'h38, 16'hFFFF); rd(7'h38, v); chk("R2 lch rw", v, 16'h03FF);
    rd(7'h39, v); chk("R2 phys invalid", v, 0);
    wr(7'h38, 3); rd(7'h39, v); chk("R2 phys map", v, 13);
    wr(7'h39, 16'h0055); rd(7'h39, v); chk("R2 phys ro", v, 13);
    wr(7'h3B, 16'hFF12); rd(7'h3B, v); chk("R4 offset", v, 16'h0012);
    wr(7'h3C, 16'hBEEF); rd(7'h3C, v); chk("R4 data", v, 16'hBEEF);
    rd(7'h10, v); chk("R4 unmapped", v, 0);
    wr(7'h3B, 0);
    wr(7'h3A, 16'hFFFF); rd(7'h3A, v); chk("R3 ctrl layout", v, 16'h000C);
  endtask

  task automatic t_read();
    logic [15:0] v;
    int a0;
    lat = 0;
    wr(7'h38, 2); wr(7'h3B, 5);
    mem[{5'd9, 6'd5}] = 16'hC0DE;
    a0 = acc_cnt;
    wr(7'h3A, 16'h0006);
    rd(7'h3A, v); chk("R5 busy high", v[8], 1);
    wait_idle();
    chk("R5 one access", acc_cnt - a0, 1);
    rd(7'h3C, v); chk("R5 read data", v, 16'hC0DE);
  endtask

  task automatic t_rmw();
    logic [15:0] v;
    int a0;
    wr(7'h38, 2); wr(7'h3B, 7); wr(7'h3C, 16'h1234);
    mem[{5'd9, 6'd7}] = 16'hABCD;
    a0 = acc_cnt;
    wr(7'h3A, 16'h0005); wait_idle();
    chk("R6 even mask", mem[{5'd9, 6'd7}], 16'h1B3D);
    chk("R6 two accesses", acc_cnt - a0, 2);
    rd(7'h3C, v); chk("R6 data kept", v, 16'h1234);
    wr(7'h38, 3);
    mem[{5'd13, 6'd7}] = 16'hABCD;
    wr(7'h3A, 16'h0005); wait_idle();
    chk("R6 odd mask", mem[{5'd13, 6'd7}], 16'hA2C4);
  endtask

  task automatic t_err();
    logic [15:0] v;
    int a0;
    a0 = acc_cnt;
    wr(7'h38, 9); wr(7'h3B, 0);
    wr(7'h3A, 16'h0006); rd(7'h3A, v); chk("R7 bad lch", v, 16'h0204);
    wr(7'h3A, 0); rd(7'h3A, v); chk("R7 err sticky", v[9], 1);
    wr(7'h38, 1); wr(7'h3A, 16'h0006); wait_idle();
    rd(7'h3A, v); chk("R8 err cleared", v[9], 0);
    a0 = acc_cnt;
    wr(7'h38, 7); wr(7'h3A, 16'h0005); rd(7'h3A, v); chk("R7 bad phys", v, 16'h0204);
    wr(7'h38, 1); wr(7'h3B, 64); wr(7'h3A, 16'h0005); rd(7'h3A, v);
    chk("R7 bad offset", v, 16'h0204);
    chk("R7 no access", acc_cnt - a0, 0);
    wr(7'h3B, 2); a0 = acc_cnt;
    wr(7'h3A, 16'h0001); rd(7'h3A, v); chk("R9 mode0 immediate", v, 16'h0000);
    chk("R9 no access", acc_cnt - a0, 0);
    wr(7'h3A, 16'h000A); rd(7'h3A, v); chk("R9 reserved mode", v, 16'h0008);
    chk("R9 reserved no access", acc_cnt - a0, 0);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int a0;
    lat = 5;
    wr(7'h38, 2); wr(7'h3B, 5);
    a0 = acc_cnt;
    wr(7'h3A, 16'h0006);
    wr(7'h3A, 16'h0006);
    wr(7'h3B, 9);
    chk("R12 req held", dn_req, 1);
    rd(7'h3A, v); chk("R12 busy held", v[8], 1);
    wait_idle();
    chk("R10 one access", acc_cnt - a0, 1);
    rd(7'h3B, v); chk("R10 offset kept", v, 5);
    lat = 0;
  endtask

  task automatic t_both();
    int a0;
    wr(7'h38, 2); wr(7'h3B, 3); wr(7'h3C, 16'hFFFF);
    mem[{5'd9, 6'd3}] = 16'h0000;
    a0 = acc_cnt;
    wr(7'h3A, 16'h0007); wait_idle();
    chk("R11 write wins", mem[{5'd9, 6'd3}], 16'hF0F0);
    chk("R11 accesses", acc_cnt - a0, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_read();
    t_rmw();
    t_err();
    t_busy();
    t_both();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule